// File: doc/BRIEF.md
# Multiplexed External Bus Controller with Per-Cycle Width

This block carries read and write requests from a 16-bit core out to external memory over a shared address/data bus. A request gives an address, two byte enables, an opcode-fetch flag and write data. The controller runs one or two bus cycles for it and then returns a one-period response with the read data. Each bus cycle has four phases: an address phase, an address-hold phase, a strobe phase and a recovery phase. The strobe phase is stretched by wait states while the ready input stays low.

Each bus cycle is either 16 or 8 bits wide. A configuration bit either pins every cycle to 8 bits or hands the choice to a width input, which is sampled during the address-hold phase. When a 16-bit word has to travel over an 8-bit cycle, the block splits it into two byte cycles: the low byte goes first, then the next address. Two more configuration bits select the strobe style. The address strobe can be a one-period latch pulse or an active-low address-valid level. The write strobes can be one write strobe plus a high-byte enable, or separate low-byte and high-byte write strobes.

One clock period here stands for one oscillator period. One wait state, which is one output-clock period, is therefore two clock periods.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Out of reset and whenever idle: `rd_n`, `wr_n` and `bhe_n` are high, `ad_oe` and `inst` are low, `req_ready` is high, and `addr_strobe` sits at its inactive level (low in latch mode, high in address-valid mode).
- R2: A request accepted at clock edge k starts its first bus cycle in the period after k. The four periods of an unstretched cycle are address, address-hold, strobe and recovery. During the address and address-hold periods `ad_out` carries the byte address with `ad_oe` high. That address is even when byte enable bit 0 is set and odd when only bit 1 is set.
- R3: With `cfg_width_dyn` = 0 every cycle is 8 bits wide. With `cfg_width_dyn` = 1, the `width_pin` value sampled at the end of the address-hold period selects 16 bits when high and 8 bits when low.
- R4: A request with both byte enables set that runs as an 8-bit cycle becomes two byte cycles: the low byte at the even address first, then address+1. The second address phase starts 3 + L periods after the first, where L is the strobe-phase length.
- R5: `ready_pin` is sampled at the end of the first strobe period and then at the end of every second period. Each low sample adds two periods to the strobe phase, with no upper limit.
- R6: In latch mode `addr_strobe` is high for exactly the address period. In address-valid mode it is low from the address period through the last strobe period and high in the recovery period.
- R7: In separate-strobe mode (`cfg_split_wr` = 1), `wr_n` goes low only when the low byte lane (an even byte) is written and `bhe_n` only when the high lane (an odd byte) is written. In combined mode `wr_n` goes low on every write and `bhe_n` marks a high-lane write. Read and write strobes are never low together.
- R8: `rd_n` falls in the period after the address-hold period, with `ad_oe` low for as long as `rd_n` is low. The data on `ad_in` is captured at the end of the last strobe period: on a 16-bit cycle each enabled lane from its own lane, on an 8-bit cycle from `ad_in[7:0]` into the addressed lane. `rsp_valid` pulses in the period after the last recovery period, carrying `rsp_rdata`, with lanes that were not read at zero. A write returns zero.
- R9: On a write `ad_oe` stays high through the strobe phase and the recovery period after the strobes rise. A 16-bit cycle drives the full word. An 8-bit cycle drives the addressed byte on `ad_out[7:0]`.
- R10: `inst` is high from the address period through the recovery period of every cycle of an opcode-fetch read. It is low for data reads, writes and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width_dyn | input | 1 | 0: all cycles 8-bit; 1: width from `width_pin` |
| cfg_adv_mode | input | 1 | 0: latch pulse strobe; 1: address-valid level |
| cfg_split_wr | input | 1 | 0: write strobe plus high-byte enable; 1: separate low/high write strobes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_fetch | input | 1 | Read is an opcode fetch |
| req_addr | input | 16 | Request address (bit 0 replaced from byte enables) |
| req_be | input | 2 | Byte enables, bit 0 low lane, bit 1 high lane; nonzero |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-period completion pulse |
| rsp_rdata | output | 16 | Read data of the completed request |
| width_pin | input | 1 | Bus width request, high for 16-bit |
| ready_pin | input | 1 | Low to insert wait states |
| ad_in | input | 16 | Bus value seen at the pads |
| ad_out | output | 16 | Address or write data toward the pads |
| ad_oe | output | 1 | Bus drive enable |
| addr_strobe | output | 1 | Latch pulse or address-valid level |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, or low-byte write strobe |
| bhe_n | output | 1 | High-byte enable, or high-byte write strobe |
| inst | output | 1 | Opcode-fetch indicator |

## Verification
Every pin result is tied to a fixed period after the accepting edge. The address shows in periods one and two. The strobes fall in period three and stay low for the expected stretched length, which follows from the ready pattern as 1 + 2·ceil((h−1)/2) periods when ready rises at strobe period h. The recovery values appear in the period after that, and the response comes one period after recovery. The bench walks each transaction period by period on falling edges and checks each pin in exactly the period where it is due. It also measures the spacing between the two address phases of a split word. Read data is predicted when the request is issued, queued, and compared when the response pulse appears.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    parameter int EBC_AW    = 16;
    parameter int EBC_DW    = 16;
    parameter int EBC_BYTE  = 8;
    localparam int EBC_LANES = EBC_DW / EBC_BYTE;
    localparam int EBC_LSB_W = (EBC_LANES > 1) ? $clog2(EBC_LANES) : 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLDA,
        ST_STRB,
        ST_WAIT,
        ST_RECOV
    } ebc_state_e;

    typedef struct packed {
        ebc_state_e              state;
        logic                    wphase;
        logic [EBC_AW-1:0]       addr;
        logic [EBC_LANES-1:0]    lanes;
        logic                    write;
        logic                    fetch;
        logic [EBC_DW-1:0]       wdata;
        logic                    wide;
        logic [EBC_DW-1:0]       rdata;
        logic                    rsp;
    } ebc_regs_t;
endpackage

// File: rtl/ebc_lane_route.sv
module ebc_lane_route
    import ebc_pkg::*;
(
    input  logic                 wide,
    input  logic [EBC_LSB_W-1:0] addr_lo,
    input  logic [EBC_LANES-1:0] lanes,
    input  logic [EBC_DW-1:0]    wdata,
    input  logic [EBC_DW-1:0]    ad_in,
    input  logic [EBC_DW-1:0]    rdata_q,
    output logic [EBC_LANES-1:0] cur_lanes,
    output logic [EBC_DW-1:0]    wdata_bus,
    output logic [EBC_DW-1:0]    rdata_next
);
    logic [EBC_LANES-1:0] narrow_mask;
    logic [EBC_BYTE-1:0]  sel_byte;

    // Narrow cycles move only the lane the address points at.
    always_comb begin
        narrow_mask = '0;
        sel_byte    = '0;
        for (int i = 0; i < EBC_LANES; i++) begin
            if (addr_lo == i[EBC_LSB_W-1:0]) begin
                narrow_mask[i] = 1'b1;
                sel_byte       = wdata[i*EBC_BYTE +: EBC_BYTE];
            end
        end
        cur_lanes = wide ? lanes : (lanes & narrow_mask);
        wdata_bus = wide ? wdata : {EBC_LANES{sel_byte}};
    end

    // Read merge: wide lanes come from their own pads, narrow from lane 0.
    for (genvar g = 0; g < EBC_LANES; g++) begin : g_rd_lane
        assign rdata_next[g*EBC_BYTE +: EBC_BYTE] =
            cur_lanes[g] ? (wide ? ad_in[g*EBC_BYTE +: EBC_BYTE] : ad_in[EBC_BYTE-1:0])
                         : rdata_q[g*EBC_BYTE +: EBC_BYTE];
    end
endmodule

// File: rtl/ebc_pin_decode.sv
module ebc_pin_decode
    import ebc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  ebc_state_e           state,
    input  logic                 write,
    input  logic                 fetch,
    input  logic [EBC_LANES-1:0] cur_lanes,
    input  logic [EBC_AW-1:0]    addr,
    input  logic [EBC_DW-1:0]    wdata_bus,
    input  logic                 cfg_adv_mode,
    input  logic                 cfg_split_wr,
    output logic [EBC_DW-1:0]    ad_out,
    output logic                 ad_oe,
    output logic                 addr_strobe,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 bhe_n,
    output logic                 inst
);
    logic addr_phase, strb_phase, in_cycle;

    always_comb begin
        addr_phase  = (state == ST_ADDR) || (state == ST_HOLDA);
        strb_phase  = (state == ST_STRB) || (state == ST_WAIT);
        in_cycle    = addr_phase || strb_phase || (state == ST_RECOV);
        ad_oe       = addr_phase || (write && (strb_phase || state == ST_RECOV));
        if (addr_phase)      ad_out = EBC_DW'(addr);
        else if (ad_oe)      ad_out = wdata_bus;
        else                 ad_out = '0;
        addr_strobe = cfg_adv_mode ? !(addr_phase || strb_phase) : (state == ST_ADDR);
        rd_n        = !(strb_phase && !write);
        wr_n        = !(strb_phase && write && (cfg_split_wr ? cur_lanes[0] : 1'b1));
        bhe_n       = !(strb_phase && write && cur_lanes[EBC_LANES-1]);
        inst        = in_cycle && fetch && !write;
    end

    assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && (!wr_n || !bhe_n)));

    assert_latch_one_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_adv_mode && $rose(addr_strobe)) |=> !addr_strobe);

    assert_bus_free_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_wdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n) || $rose(bhe_n)) |-> ad_oe);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_width_dyn,
    input  logic                 cfg_adv_mode,
    input  logic                 cfg_split_wr,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_fetch,
    input  logic [EBC_AW-1:0]    req_addr,
    input  logic [EBC_LANES-1:0] req_be,
    input  logic [EBC_DW-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [EBC_DW-1:0]    rsp_rdata,
    input  logic                 width_pin,
    input  logic                 ready_pin,
    input  logic [EBC_DW-1:0]    ad_in,
    output logic [EBC_DW-1:0]    ad_out,
    output logic                 ad_oe,
    output logic                 addr_strobe,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 bhe_n,
    output logic                 inst
);
    ebc_regs_t r_q, r_d;

    logic [EBC_LANES-1:0] cur_lanes;
    logic [EBC_DW-1:0]    wdata_bus;
    logic [EBC_DW-1:0]    rdata_next;
    logic [EBC_LANES-1:0] lanes_left;
    logic [EBC_LSB_W-1:0] first_lane;

    ebc_lane_route u_route (
        .wide       (r_q.wide),
        .addr_lo    (r_q.addr[EBC_LSB_W-1:0]),
        .lanes      (r_q.lanes),
        .wdata      (r_q.wdata),
        .ad_in      (ad_in),
        .rdata_q    (r_q.rdata),
        .cur_lanes  (cur_lanes),
        .wdata_bus  (wdata_bus),
        .rdata_next (rdata_next)
    );

    ebc_pin_decode u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (r_q.state),
        .write        (r_q.write),
        .fetch        (r_q.fetch),
        .cur_lanes    (cur_lanes),
        .addr         (r_q.addr),
        .wdata_bus    (wdata_bus),
        .cfg_adv_mode (cfg_adv_mode),
        .cfg_split_wr (cfg_split_wr),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .addr_strobe  (addr_strobe),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .bhe_n        (bhe_n),
        .inst         (inst)
    );

    always_comb begin
        first_lane = '0;
        for (int i = EBC_LANES - 1; i >= 0; i--) begin
            if (req_be[i]) first_lane = i[EBC_LSB_W-1:0];
        end
        lanes_left = r_q.lanes & ~cur_lanes;
    end

    always_comb begin
        r_d     = r_q;
        r_d.rsp = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = {req_addr[EBC_AW-1:EBC_LSB_W], first_lane};
                    r_d.lanes = req_be;
                    r_d.write = req_write;
                    r_d.fetch = req_fetch;
                    r_d.wdata = req_wdata;
                    r_d.rdata = '0;
                    r_d.state = ST_ADDR;
                end
            end
            ST_ADDR:  r_d.state = ST_HOLDA;
            ST_HOLDA: begin
                r_d.wide  = cfg_width_dyn && width_pin;
                r_d.state = ST_STRB;
            end
            ST_STRB: begin
                if (ready_pin) begin
                    r_d.state = ST_RECOV;
                    if (!r_q.write) r_d.rdata = rdata_next;
                end else begin
                    r_d.state  = ST_WAIT;
                    r_d.wphase = 1'b0;
                end
            end
            ST_WAIT: begin
                r_d.wphase = !r_q.wphase;
                if (r_q.wphase && ready_pin) begin
                    r_d.state = ST_RECOV;
                    if (!r_q.write) r_d.rdata = rdata_next;
                end
            end
            ST_RECOV: begin
                if (lanes_left != '0) begin
                    r_d.lanes = lanes_left;
                    r_d.addr  = r_q.addr + 1'b1;
                    r_d.state = ST_ADDR;
                end else begin
                    r_d.rsp   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_valid = r_q.rsp;
    assign rsp_rdata = r_q.rdata;

    assert_wait_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STRB && !ready_pin) |=> ##1 (!rd_n || !wr_n || !bhe_n));

    assert_narrow_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STRB && $past(!cfg_width_dyn) && cfg_split_wr) |-> !(!wr_n && !bhe_n));

    assert_rsp_after_recov_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(r_q.state) == ST_RECOV);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && bhe_n && !ad_oe && !inst));
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_width_dyn = 1'b1, cfg_adv_mode = 1'b0, cfg_split_wr = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        width_pin = 1'b1, ready_pin = 1'b0;
    logic [15:0] ad_in, ad_out, rsp_rdata;
    logic        req_ready, rsp_valid, ad_oe, addr_strobe, rd_n, wr_n, bhe_n, inst;

    int checks = 0, fails = 0, cyc = 0, hold_len = 1, sc = 0;
    logic [15:0] lat = '0;
    logic [15:0] mon_exp;
    logic [15:0] exp_q[$];

    always #2.5 clk = !clk;

    ext_bus_ctrl u_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_width_dyn(cfg_width_dyn), .cfg_adv_mode(cfg_adv_mode),
        .cfg_split_wr(cfg_split_wr), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_fetch(req_fetch), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .width_pin(width_pin), .ready_pin(ready_pin), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .addr_strobe(addr_strobe), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
        .inst(inst)
    );

    function automatic logic [15:0] mem_val(input logic [15:0] a);
        return {~a[7:0], a[7:0] + 8'h11};
    endfunction

    assign ad_in = mem_val(lat);

    always @(posedge clk) cyc <= cyc + 1;

    // External memory model: latch address, drive ready after hold_len strobe periods.
    always @(negedge clk) begin
        if (ad_oe) lat = ad_out;
        if (!rd_n || !wr_n || !bhe_n) sc = sc + 1;
        else sc = 0;
        ready_pin = (sc >= hold_len);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor for responses.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", 32'(rsp_rdata), 0);
            else begin
                mon_exp = exp_q.pop_front();
                chk(rsp_rdata == mon_exp, "R8 response data", 32'(rsp_rdata), 32'(mon_exp));
            end
        end
    end

    task automatic run_txn(input bit wr, input bit fe, input logic [15:0] a, input logic [1:0] be,
                           input logic [15:0] wd, input int hold);
        bit          wide_e;
        int          ncyc, lowe, cnt;
        int          t0 [2];
        logic [15:0] ca [2];
        logic [1:0]  ln [2];
        logic [15:0] er, fv;
        bit          low;
        wide_e = cfg_width_dyn && width_pin;
        lowe = (hold <= 1) ? 1 : ((hold % 2 == 1) ? hold : hold + 1);
        if (!wide_e && be == 2'b11) begin
            ncyc = 2; ca[0] = {a[15:1], 1'b0}; ca[1] = {a[15:1], 1'b1};
            ln[0] = 2'b01; ln[1] = 2'b10;
        end else begin
            ncyc = 1; ca[0] = {a[15:1], ~be[0]};
            ln[0] = wide_e ? be : (be[0] ? 2'b01 : 2'b10);
        end
        er = '0;
        for (int i = 0; i < ncyc; i++) begin
            fv = mem_val(ca[i]);
            for (int k = 0; k < 2; k++)
                if (ln[i][k]) er[k*8 +: 8] = wide_e ? fv[k*8 +: 8] : fv[7:0];
        end
        exp_q.push_back(wr ? 16'h0 : er);
        hold_len = hold;
        @(negedge clk);
        chk(req_ready, "R1 ready while idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_fetch = fe; req_addr = a; req_be = be; req_wdata = wd;
        @(posedge clk);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            t0[i] = cyc;
            chk(addr_strobe == !cfg_adv_mode, "R6 strobe in address period", 32'(addr_strobe), 32'(!cfg_adv_mode));
            chk(ad_oe && ad_out == ca[i], "R2 address driven", 32'(ad_out), 32'(ca[i]));
            chk(inst == (fe && !wr), "R10 inst in address period", 32'(inst), 32'(fe && !wr));
            if (i > 0) chk(t0[1] - t0[0] == 3 + lowe, "R4 second cycle spacing", 32'(t0[1] - t0[0]), 32'(3 + lowe));
            @(negedge clk);
            chk(addr_strobe == 1'b0, "R6 strobe in hold period", 32'(addr_strobe), 0);
            chk(ad_out == ca[i] && rd_n && wr_n, "R2 address held", 32'(ad_out), 32'(ca[i]));
            @(negedge clk);
            if (!wr) begin
                chk(!rd_n && !ad_oe, "R8 read strobe low, bus released", {rd_n, ad_oe}, 0);
            end else begin
                chk(wr_n == !(cfg_split_wr ? ln[i][0] : 1'b1), "R7 write strobe", 32'(wr_n),
                    32'(!(cfg_split_wr ? ln[i][0] : 1'b1)));
                chk(bhe_n == !ln[i][1], "R7 high-byte strobe", 32'(bhe_n), 32'(!ln[i][1]));
                if (wide_e) chk(ad_oe && ad_out == wd, "R9 word write data", 32'(ad_out), 32'(wd));
                else chk(ad_oe && ad_out[7:0] == (ca[i][0] ? wd[15:8] : wd[7:0]), "R9 byte write data",
                         32'(ad_out[7:0]), 32'(ca[i][0] ? wd[15:8] : wd[7:0]));
            end
            cnt = 1;
            low = 1'b1;
            while (low && cnt < 64) begin
                @(negedge clk);
                low = wr ? (!wr_n || !bhe_n) : !rd_n;
                if (low) cnt++;
            end
            chk(cnt == lowe, "R5 strobe length", 32'(cnt), 32'(lowe));
            chk(rd_n && wr_n && bhe_n, "R7 strobes released", {rd_n, wr_n, bhe_n}, 32'h7);
            chk(addr_strobe == cfg_adv_mode, "R6 strobe in recovery", 32'(addr_strobe), 32'(cfg_adv_mode));
            chk(ad_oe == wr, "R9 data hold after strobe", 32'(ad_oe), 32'(wr));
            if (wr && wide_e) chk(ad_out == wd, "R9 held word", 32'(ad_out), 32'(wd));
            chk(inst == (fe && !wr), "R10 inst in recovery", 32'(inst), 32'(fe && !wr));
        end
        @(negedge clk);
        chk(rsp_valid, "R8 response timing", 32'(rsp_valid), 1);
        chk(inst == 1'b0 && !ad_oe, "R10 idle after cycle", {inst, ad_oe}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_n && wr_n && bhe_n && !ad_oe && !inst && !addr_strobe && req_ready && !rsp_valid,
            "R1 reset levels", {rd_n, wr_n, bhe_n, ad_oe, inst, addr_strobe, req_ready, rsp_valid}, 32'hE2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rd_n && wr_n && bhe_n && !ad_oe && req_ready, "R1 idle after reset", {rd_n, wr_n, bhe_n, ad_oe}, 32'hE);
        // R3 wide by pin, fetch read (R10)
        run_txn(1'b0, 1'b1, 16'h1234, 2'b11, 16'h0, 1);
        run_txn(1'b0, 1'b0, 16'h2000, 2'b10, 16'h0, 1);
        // R3 config forces narrow; R4 split read
        cfg_width_dyn = 1'b0;
        run_txn(1'b0, 1'b1, 16'h3456, 2'b11, 16'h0, 1);
        // R3 narrow chosen by pin low; R7 separate strobes, split write
        cfg_width_dyn = 1'b1; width_pin = 1'b0; cfg_split_wr = 1'b1;
        run_txn(1'b1, 1'b0, 16'h4000, 2'b11, 16'hBEEF, 1);
        run_txn(1'b1, 1'b0, 16'h4101, 2'b10, 16'h5A3C, 1);
        // combined strobes
        cfg_split_wr = 1'b0;
        run_txn(1'b1, 1'b0, 16'h5000, 2'b10, 16'hCAFE, 1);
        width_pin = 1'b1;
        run_txn(1'b1, 1'b0, 16'h5100, 2'b01, 16'h1357, 1);
        cfg_split_wr = 1'b1;
        run_txn(1'b1, 1'b0, 16'h5200, 2'b11, 16'h2468, 1);
        // R5 wait states
        run_txn(1'b0, 1'b0, 16'h6000, 2'b11, 16'h0, 2);
        run_txn(1'b0, 1'b0, 16'h6100, 2'b01, 16'h0, 4);
        run_txn(1'b1, 1'b0, 16'h6200, 2'b11, 16'h9ABC, 5);
        // R6 address-valid mode, wide then split with waits
        cfg_adv_mode = 1'b1;
        @(negedge clk);
        chk(addr_strobe == 1'b1, "R1 idle level address-valid", 32'(addr_strobe), 1);
        run_txn(1'b0, 1'b1, 16'h7000, 2'b11, 16'h0, 1);
        width_pin = 1'b0;
        run_txn(1'b0, 1'b0, 16'h7100, 2'b11, 16'h0, 3);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all responses seen", 32'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog actual=hung expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule